// File: doc/BRIEF.md
# Pulse-Width Remote Command Receiver

This block sits on the receiving end of a slow control channel. The channel encodes each bit as one high pulse, and the width of that pulse carries the bit value. The block takes the already-sliced line level and a strobe that fires once per audio frame. It measures how long each high pulse lasts in frame periods and decides whether the pulse is a zero or a one. Bits are shifted in most significant first. Bits that arrive back to back form one block. A long stretch of low line closes the block, and only then is the block published.

A normal block holds 16 bits: a command byte followed by a data byte. A longer block of 24 bits puts an extension byte in front of these two. Once a block closes with one of these two lengths, the bytes are copied to the outputs and a single-cycle valid strobe fires. A block with any other length raises the error strobe and is discarded. A pulse that stays high for too long also raises the error strobe and abandons the block in progress. The outputs keep the last good block until a newer good block replaces it.

Top module: `rc_pwm_receiver`

## Requirements
- R1: A pulse's width is the number of clock edges on which both `line_i` and `frame_tick_i` are high during that pulse. A width from 0 to 31 decodes as bit 0. A width from 32 to 100 decodes as bit 1.
- R2: Bits are taken most significant first. In a 16-bit block, the first 8 bits form `cmd_o` and the last 8 bits form `data_o`.
- R3: A 24-bit block puts its first 8 bits on `ext_o` and sets `ext_present_o` to 1. A 16-bit block sets `ext_o` to 0 and `ext_present_o` to 0.
- R4: A block ends only when the line has stayed low for more than 128 frame ticks. A low stretch of exactly 128 ticks inside a block does not split the block.
- R5: The outputs change only when a block is accepted. At that moment `valid_o` is high for exactly one cycle.
- R6: A block that closes with a bit count other than 16 or 24 gives one `err_o` pulse and no `valid_o`. The outputs keep their old values. Counts above 24 are handled the same way.
- R7: A high pulse longer than 100 ticks gives one `err_o` pulse while the line is still high. The rest of that block is dropped without a further error, and decoding starts again after the next end-of-block gap.
- R8: After reset, all byte outputs, `ext_present_o`, `valid_o` and `err_o` are 0.
- R9: An end-of-block gap with no bits received gives neither `valid_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronized level of the pulse line |
| frame_tick_i | input | 1 | One-cycle strobe, once per frame period |
| cmd_o | output | 8 | Command byte of the last accepted block |
| data_o | output | 8 | Data byte of the last accepted block |
| ext_o | output | 8 | Extension byte of the last accepted block, 0 if none |
| ext_present_o | output | 1 | Last accepted block carried an extension byte |
| valid_o | output | 1 | One-cycle strobe when the outputs are updated |
| err_o | output | 1 | One-cycle strobe on a bad block length or an overlong pulse |

## Verification
The bench drives pulses of width 0, 31, 32 and 100 ticks. A comparator that is off by one tick would turn one of these bits into the wrong value and corrupt the bytes. It places a low stretch of exactly 128 ticks inside a block and another of 129 ticks. A gap detector with the wrong bound would either split the good block into two errors or merge the two halves into one good block. It sends blocks of 8, 15, 17 and 25 bits and a 24-bit block followed by a 16-bit one. These catch a length check that accepts a bad count, a shift register that keeps stale extension bits, and outputs that move on a rejected block. It also sends a 104-tick pulse in the middle of a block. A design that fails to drop the rest of that block would report a second error or publish garbage.

// File: rtl/pwmrx_pkg.sv
package pwmrx_pkg;

    localparam int BYTE_W     = 8;
    localparam int SHORT_BITS = 2 * BYTE_W;
    localparam int LONG_BITS  = 3 * BYTE_W;
    localparam int BITCNT_W   = $clog2(LONG_BITS + 2);

    localparam logic [BITCNT_W-1:0] SHORT_CNT = BITCNT_W'(SHORT_BITS);
    localparam logic [BITCNT_W-1:0] LONG_CNT  = BITCNT_W'(LONG_BITS);

    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [BITCNT_W-1:0]  bitcnt_t;
    typedef logic [LONG_BITS-1:0] shreg_t;

    // events produced by the pulse timer, one cycle each
    typedef struct packed {
        logic bit_vld;
        logic bit_val;
        logic gap_end;
        logic overlong;
    } pulse_evt_t;

    typedef struct packed {
        logic  has_ext;
        byte_t ext;
        byte_t cmd;
        byte_t data;
    } rc_block_t;

    typedef enum logic {
        ASM_COLLECT = 1'b0,
        ASM_DISCARD = 1'b1
    } asm_state_t;

    function automatic logic count_ok(input bitcnt_t n);
        return (n == SHORT_CNT) || (n == LONG_CNT);
    endfunction

    function automatic rc_block_t unpack_block(input shreg_t sr, input logic is_long);
        rc_block_t b;
        b.has_ext = is_long;
        b.ext     = is_long ? sr[2*BYTE_W +: BYTE_W] : '0;
        b.cmd     = sr[BYTE_W +: BYTE_W];
        b.data    = sr[0 +: BYTE_W];
        return b;
    endfunction

endpackage

// File: rtl/rcv_pulse_timer.sv
module rcv_pulse_timer
    import pwmrx_pkg::*;
#(
    parameter int unsigned SPLIT_TICKS = 32,
    parameter int unsigned GAP_TICKS   = 128,
    parameter int unsigned MAXH_TICKS  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  logic       tick_i,
    output pulse_evt_t evt_o
);

    localparam int HW = $clog2(MAXH_TICKS + 2);
    localparam int LW = $clog2(GAP_TICKS + 2);
    localparam logic [HW-1:0] SPLIT_C = HW'(SPLIT_TICKS);
    localparam logic [HW-1:0] MAXH_C  = HW'(MAXH_TICKS);
    localparam logic [LW-1:0] GAP_C   = LW'(GAP_TICKS);

    logic          line_q;
    logic [HW-1:0] hcnt;   // ticks seen while high, saturates at MAXH+1
    logic [LW-1:0] lcnt;   // ticks seen while low, saturates at GAP+1
    logic          fall;

    assign fall = line_q & ~line_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            hcnt   <= '0;
            lcnt   <= '0;
            evt_o  <= '0;
        end else begin
            line_q         <= line_i;
            evt_o.bit_vld  <= fall && (hcnt <= MAXH_C);
            evt_o.bit_val  <= (hcnt >= SPLIT_C);
            evt_o.overlong <= line_i && tick_i && (hcnt == MAXH_C);
            evt_o.gap_end  <= !line_i && tick_i && (lcnt == GAP_C);

            if (!line_i)
                hcnt <= '0;
            else if (tick_i && (hcnt <= MAXH_C))
                hcnt <= hcnt + 1'b1;

            if (line_i)
                lcnt <= '0;
            else if (tick_i && (lcnt <= GAP_C))
                lcnt <= lcnt + 1'b1;
        end
    end

    // R4: a block cannot close in the same cycle that a bit is delivered
    a_r4_no_gap_with_bit: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.gap_end && evt_o.bit_vld));

    // R7: an overlong flag and a bit event never coincide
    a_r7_overlong_not_bit: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.overlong && evt_o.bit_vld));

endmodule

// File: rtl/rcv_block_asm.sv
module rcv_block_asm
    import pwmrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pulse_evt_t evt_i,
    output logic       done_o,
    output logic       err_o,
    output rc_block_t  blk_o
);

    asm_state_t state;
    shreg_t     sr;
    bitcnt_t    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ASM_COLLECT;
            sr     <= '0;
            cnt    <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            blk_o  <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            unique case (state)
                ASM_COLLECT: begin
                    if (evt_i.overlong) begin
                        err_o <= 1'b1;
                        sr    <= '0;
                        cnt   <= '0;
                        state <= ASM_DISCARD;
                    end else if (evt_i.bit_vld) begin
                        sr <= {sr[LONG_BITS-2:0], evt_i.bit_val};
                        if (cnt <= LONG_CNT)
                            cnt <= cnt + 1'b1;
                    end else if (evt_i.gap_end && (cnt != '0)) begin
                        if (count_ok(cnt)) begin
                            done_o <= 1'b1;
                            blk_o  <= unpack_block(sr, cnt == LONG_CNT);
                        end else begin
                            err_o <= 1'b1;
                        end
                        sr  <= '0;
                        cnt <= '0;
                    end
                end
                ASM_DISCARD: begin
                    if (evt_i.overlong)
                        err_o <= 1'b1;
                    else if (evt_i.gap_end)
                        state <= ASM_COLLECT;
                end
                default: state <= ASM_COLLECT;
            endcase
        end
    end

    // R6: acceptance and error never fire together
    a_r6_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    // R6: bit counter stays within its saturation bound
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LONG_CNT + 1'b1);

    // R7: an overlong pulse is reported on the next cycle
    a_r7_overlong_err: assert property (@(posedge clk) disable iff (rst)
        evt_i.overlong |=> err_o);

endmodule

// File: rtl/rc_pwm_receiver.sv
module rc_pwm_receiver
    import pwmrx_pkg::*;
#(
    parameter int unsigned SPLIT_TICKS = 32,
    parameter int unsigned GAP_TICKS   = 128,
    parameter int unsigned MAXH_TICKS  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              frame_tick_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] ext_o,
    output logic              ext_present_o,
    output logic              valid_o,
    output logic              err_o
);

    pulse_evt_t evt;
    rc_block_t  blk;
    logic       done;

    rcv_pulse_timer #(
        .SPLIT_TICKS(SPLIT_TICKS),
        .GAP_TICKS  (GAP_TICKS),
        .MAXH_TICKS (MAXH_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .line_i(line_i),
        .tick_i(frame_tick_i),
        .evt_o (evt)
    );

    rcv_block_asm u_asm (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .done_o(done),
        .err_o (err_o),
        .blk_o (blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o         <= '0;
            data_o        <= '0;
            ext_o         <= '0;
            ext_present_o <= 1'b0;
            valid_o       <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) begin
                cmd_o         <= blk.cmd;
                data_o        <= blk.data;
                ext_o         <= blk.ext;
                ext_present_o <= blk.has_ext;
            end
        end
    end

    // R5: valid is a single-cycle strobe
    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R5: outputs hold unless a block is being published
    a_r5_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(cmd_o) && $stable(data_o) &&
                      $stable(ext_o) && $stable(ext_present_o)));

endmodule

// File: tb/tb_rc_pwm_receiver.sv
`timescale 1ns/1ps
module tb_rc_pwm_receiver;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic div = 1'b0;
    wire  tick = (div == 1'b0);

    logic [7:0] cmd, data, ext;
    logic       has_ext, valid, err;

    always #2.5 clk = ~clk;
    always @(posedge clk) div <= ~div;

    rc_pwm_receiver dut (
        .clk(clk), .rst(rst), .line_i(line), .frame_tick_i(tick),
        .cmd_o(cmd), .data_o(data), .ext_o(ext), .ext_present_o(has_ext),
        .valid_o(valid), .err_o(err)
    );

    int nchk = 0, nfail = 0, vcnt = 0, ecnt = 0;
    bit finished = 0;
    logic [7:0] exp_cmd = 0, exp_data = 0, exp_ext = 0;
    logic       exp_has = 0;

    always @(negedge clk) if (!rst) begin
        if (valid) vcnt++;
        if (err)   ecnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // each iteration consumes exactly one sampled tick
    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        line = 1'b1;
        if (hi == 0) @(negedge clk);
        else wait_ticks(hi);
        line = 1'b0;
        wait_ticks(lo);
    endtask

    // mode 0: random widths in class, mode 1: boundary widths
    task automatic send_bits(input int n, input logic [31:0] val, input int mode,
                             input int split_at, input int split_lo);
        for (int i = n - 1; i >= 0; i--) begin
            int hi, lo;
            bit b;
            b = val[i];
            if (mode == 1) hi = b ? ((i % 2) ? 32 : 100) : ((i % 2) ? 31 : 0);
            else           hi = b ? 32 + int'($urandom % 69) : 1 + int'($urandom % 31);
            if ((n - 1 - i) == split_at) lo = split_lo;
            else lo = b ? 1 + int'($urandom % 40) : 1 + int'($urandom % 60);
            pulse(hi, lo);
        end
    endtask

    function automatic bit good_len(input int n);
        return (n == 16) || (n == 24);
    endfunction

    task automatic check_outputs(input string tag);
        chk({tag, " cmd"},  cmd, exp_cmd);
        chk({tag, " data"}, data, exp_data);
        chk({tag, " ext"},  ext, exp_ext);
        chk({tag, " has_ext"}, has_ext, exp_has);
    endtask

    task automatic run_block(input int n, input logic [31:0] val, input int mode, input string tag);
        int v0, e0;
        v0 = vcnt; e0 = ecnt;
        send_bits(n, val, mode, -1, 0);
        wait_ticks(140);
        if (good_len(n)) begin
            exp_has  = (n == 24);
            exp_ext  = (n == 24) ? val[23:16] : 8'h00;
            exp_cmd  = val[15:8];
            exp_data = val[7:0];
            chk({tag, " R5 valid count"}, vcnt - v0, 1);
            chk({tag, " R6 no err"}, ecnt - e0, 0);
            check_outputs({tag, " R2/R3"});
        end else begin
            chk({tag, " R6 err count"}, ecnt - e0, 1);
            chk({tag, " R6 no valid"}, vcnt - v0, 0);
            check_outputs({tag, " R6 held"});
        end
    endtask

    initial begin
        void'($urandom(32'h5A17C0DE));
        repeat (5) @(negedge clk);
        // R8: reset state
        chk("R8 cmd", cmd, 0); chk("R8 data", data, 0); chk("R8 ext", ext, 0);
        chk("R8 has_ext", has_ext, 0); chk("R8 valid", valid, 0); chk("R8 err", err, 0);
        rst = 1'b0;
        wait_ticks(1);

        // R9: idle gap with nothing received
        wait_ticks(140);
        chk("R9 no valid", vcnt, 0);
        chk("R9 no err", ecnt, 0);

        // R1: boundary widths 0/31 -> 0, 32/100 -> 1
        run_block(16, 32'h0000_A5C3, 1, "R1 boundary16");
        run_block(24, 32'h003C_96F0, 1, "R1 boundary24");

        // R3: extension cleared by a following short block
        run_block(24, 32'h00FF_1234, 0, "R3 long");
        run_block(16, 32'h0000_8001, 0, "R3 short-after-long");

        // R4: 128-tick low inside a block keeps it whole
        begin
            int v0, e0;
            v0 = vcnt; e0 = ecnt;
            send_bits(16, 32'h0000_6B2D, 0, 7, 128);
            wait_ticks(140);
            exp_has = 0; exp_ext = 0; exp_cmd = 8'h6B; exp_data = 8'h2D;
            chk("R4 128 valid", vcnt - v0, 1);
            chk("R4 128 no err", ecnt - e0, 0);
            check_outputs("R4 128");
        end
        // R4: 129-tick low splits into two 8-bit blocks
        begin
            int v0, e0;
            v0 = vcnt; e0 = ecnt;
            send_bits(16, 32'h0000_1EE1, 0, 7, 129);
            wait_ticks(140);
            chk("R4 129 two errs", ecnt - e0, 2);
            chk("R4 129 no valid", vcnt - v0, 0);
            check_outputs("R4 129 held");
        end

        // R6: bad lengths
        run_block(8,  32'h0000_00AA, 0, "R6 len8");
        run_block(15, 32'h0000_7FFF, 0, "R6 len15");
        run_block(17, 32'h0001_5555, 0, "R6 len17");
        run_block(25, 32'h01AB_CDEF, 0, "R6 len25");

        // R7: overlong pulse mid block
        begin
            int v0, e0;
            v0 = vcnt; e0 = ecnt;
            send_bits(5, 32'h0000_0015, 0, -1, 0);
            line = 1'b1;
            wait_ticks(104);
            chk("R7 err while high", ecnt - e0, 1);
            line = 1'b0;
            wait_ticks(20);
            send_bits(11, 32'h0000_05A5, 0, -1, 0);
            wait_ticks(140);
            chk("R7 single err", ecnt - e0, 1);
            chk("R7 no valid", vcnt - v0, 0);
            check_outputs("R7 held");
        end
        run_block(16, 32'h0000_C0DE, 0, "R7 recovery");

        // random blocks
        for (int k = 0; k < 22; k++) begin
            int r, n;
            r = int'($urandom % 8);
            if (r < 3)       n = 16;
            else if (r < 6)  n = 24;
            else if (r == 6) n = 1 + int'($urandom % 15);
            else             n = 17 + int'($urandom % 9);
            run_block(n, $urandom, 0, "rand R2");
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule